// File: doc/BRIEF.md
# Framed Register-Write Command Decoder

This block sits behind a byte-oriented serial receiver. It looks for command frames in the incoming byte stream and turns each encoded word in a frame into a register write. A frame opens with a five-byte header, carries any number of two-byte words, and closes with one delimiter byte. Each word is sent high byte first. Every word carries redundant inverted copies of two value bits and two bits fixed at zero. Because of this, no word byte can ever equal the delimiter. The decoder checks that redundancy and drops any word that breaks it.

Decoded writes land in a small banked register file. A bank-select register and a control register are reachable from every bank. The protocol-trigger match bytes, their masks and a serial-mode field live in bank 2. In bank 0, two addresses act as request strobes instead of storage: one asks for a sample-buffer dump and one asks for a trigger status byte.

Top module: `cmdfr_decoder`

The decoder has four states:
- `ST_HUNT` waits for header byte 0x40.
- `ST_HDR` matches header bytes two to five. A mismatch goes back to `ST_HUNT`, except a mismatching 0x40, which stays in `ST_HDR` at position two.
- `ST_WHI` takes a word's high byte. A 0x7E here ends the frame and returns to `ST_HUNT`.
- `ST_WLO` takes the low byte, decodes the word and returns to `ST_WHI`. A 0x7E here aborts the frame and returns to `ST_HUNT`.

## Requirements
- R1: A frame is recognised only after the exact bytes 0x40, 0x4C, 0x44, 0x53, 0x7E. A mismatching byte restarts the search. A mismatching 0x40 counts as the first header byte of a new attempt. Words outside a frame cause no write.
- R2: A word w arrives high byte first. Its value is {w[13:12], w[5:0]} and its address is w[11:8]. One cycle after the low byte is accepted, `wr_strobe` pulses for one cycle. At the same time, `wr_addr`, `wr_data` and `wr_bank` show the address, the value and the bank that was active before the write.
- R3: A word is valid only if w[15]=0, w[7]=0, w[6]=~w[5] and w[14]=~w[13]. An invalid word causes no write and no strobe. It sets `word_err`, which stays set until reset. Later words in the same frame are still decoded.
- R4: A 0x7E received in place of a high byte ends the frame. `frame_done` pulses one cycle later. Words after that cause no write until a new header arrives.
- R5: A 0x7E received in place of a low byte aborts the frame. `frame_abort` pulses one cycle later and the half-received word is discarded.
- R6: A write to address 15 in any bank stores the value. Its bits 1:0 become `bank_sel`, which sets the bank of all later writes.
- R7: In bank 2, addresses 0..3 write match bytes 0..3, with slot k at bits 8k+7:8k of `pt_match`. Addresses 4..7 write the masks for slots 0..3 into `pt_mask` in the same layout. Address 8 stores value bits 1:0 in `spi_mode`.
- R8: In bank 0 only, a write to address 1 pulses `dump_req` and a write to address 2 pulses `status_req`, each together with `wr_strobe`. These addresses pulse nothing in other banks.
- R9: A write to address 14 in any bank stores the value in `ctl_q`. Its bit meanings are: 0 capture FSM reset, 1 arm, 3 force capture, 6 ADC reset, 7 LED.
- R10: After reset, all outputs and registers are zero, except `pt_mask`, which is all ones.
- R11: Bytes presented while `in_valid` is low are ignored, including 0x7E in the middle of a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Byte on `in_byte` is valid this cycle |
| in_byte | input | 8 | Received byte |
| wr_strobe | output | 1 | One-cycle pulse per accepted word |
| wr_bank | output | 2 | Bank active when the word was decoded |
| wr_addr | output | 4 | Decoded register address |
| wr_data | output | 8 | Decoded register value |
| dump_req | output | 1 | Buffer dump request pulse |
| status_req | output | 1 | Trigger status request pulse |
| frame_done | output | 1 | Pulse on a frame closed at a word boundary |
| frame_abort | output | 1 | Pulse on a frame cut in mid-word |
| word_err | output | 1 | Sticky flag for a word that failed the redundancy check |
| bank_sel | output | 2 | Current bank |
| ctl_q | output | 8 | Control register |
| spi_mode | output | 2 | Serial trigger mode (0 also means two-wire) |
| pt_match | output | 32 | Four trigger match bytes |
| pt_mask | output | 32 | Four trigger mask bytes |

## Verification
If the state register is wrong, the effect shows within a word or two. A missed header leaves a whole frame without strobes. Losing byte parity inside a frame shifts the decoded fields, so `wr_addr` and `wr_data` are wrong on the very next strobe. A misrouted bank shows up on the register outputs the cycle after the write. The value sweeps therefore compare every strobe and every trigger byte directly against the arithmetic encoding. The corruption sweep confirms that the stored byte stays put when a word is rejected.

// File: rtl/cmdfr_pkg.sv
package cmdfr_pkg;

    localparam int          HDR_LEN  = 5;
    localparam int          IDX_W    = $clog2(HDR_LEN);
    localparam logic [7:0]  DELIM    = 8'h7E;

    localparam logic [3:0]  A_DUMP   = 4'd1;
    localparam logic [3:0]  A_STAT   = 4'd2;
    localparam logic [3:0]  A_SPIM   = 4'd8;
    localparam logic [3:0]  A_CTL    = 4'd14;
    localparam logic [3:0]  A_BANK   = 4'd15;
    localparam logic [1:0]  BANK_REQ = 2'd0;
    localparam logic [1:0]  BANK_PT  = 2'd2;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_HDR,
        ST_WHI,
        ST_WLO
    } dec_state_e;

    function automatic logic [7:0] hdr_byte(input logic [IDX_W-1:0] idx);
        case (idx)
            3'd0:    return 8'h40;
            3'd1:    return 8'h4C;
            3'd2:    return 8'h44;
            3'd3:    return 8'h53;
            default: return 8'h7E;
        endcase
    endfunction

endpackage

// File: rtl/cmdfr_word_unpack.sv
module cmdfr_word_unpack (
    input  logic [15:0] word,
    output logic [3:0]  addr,
    output logic [7:0]  value,
    output logic        ok
);
    always_comb begin
        addr  = word[11:8];
        value = {word[13:12], word[5:0]};
        ok    = !word[15] && !word[7]
             && (word[6]  == !word[5])
             && (word[14] == !word[13]);
    end
endmodule

// File: rtl/cmdfr_regbank.sv
module cmdfr_regbank
    import cmdfr_pkg::*;
#(
    parameter int SLOTS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [1:0]         bank,
    input  logic [3:0]         addr,
    input  logic [7:0]         data,
    output logic [1:0]         bank_sel,
    output logic [7:0]         ctl_q,
    output logic [1:0]         spi_mode,
    output logic [SLOTS*8-1:0] pt_match,
    output logic [SLOTS*8-1:0] pt_mask
);
    localparam int MASK_BASE = SLOTS;

    logic [7:0] bank_reg_q;
    logic       pt_we;

    assign pt_we    = we && (bank == BANK_PT);
    assign bank_sel = bank_reg_q[1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_reg_q <= '0;
            ctl_q      <= '0;
            spi_mode   <= '0;
        end else if (we) begin
            if (addr == A_BANK) bank_reg_q <= data;
            if (addr == A_CTL)  ctl_q      <= data;
            if (pt_we && addr == A_SPIM) spi_mode <= data[1:0];
        end
    end

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pt_match[k*8 +: 8] <= 8'h00;
                pt_mask[k*8 +: 8]  <= 8'hFF;
            end else if (pt_we) begin
                if (addr == 4'(k))             pt_match[k*8 +: 8] <= data;
                if (addr == 4'(MASK_BASE + k)) pt_mask[k*8 +: 8]  <= data;
            end
        end
    end
endmodule

// File: rtl/cmdfr_decoder.sv
module cmdfr_decoder
    import cmdfr_pkg::*;
#(
    parameter int PT_SLOTS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [7:0]            in_byte,
    output logic                  wr_strobe,
    output logic [1:0]            wr_bank,
    output logic [3:0]            wr_addr,
    output logic [7:0]            wr_data,
    output logic                  dump_req,
    output logic                  status_req,
    output logic                  frame_done,
    output logic                  frame_abort,
    output logic                  word_err,
    output logic [1:0]            bank_sel,
    output logic [7:0]            ctl_q,
    output logic [1:0]            spi_mode,
    output logic [PT_SLOTS*8-1:0] pt_match,
    output logic [PT_SLOTS*8-1:0] pt_mask
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HDR_LEN - 1);

    dec_state_e       state_q, state_d;
    logic [IDX_W-1:0] hidx_q, hidx_d;
    logic [7:0]       hi_q;

    logic [3:0] u_addr;
    logic [7:0] u_val;
    logic       u_ok;
    logic       is_delim, ev_word_ok, ev_word_bad, ev_done, ev_abort;

    cmdfr_word_unpack u_unpack (
        .word  ({hi_q, in_byte}),
        .addr  (u_addr),
        .value (u_val),
        .ok    (u_ok)
    );

    assign is_delim    = (in_byte == DELIM);
    assign ev_done     = in_valid && (state_q == ST_WHI) && is_delim;
    assign ev_abort    = in_valid && (state_q == ST_WLO) && is_delim;
    assign ev_word_ok  = in_valid && (state_q == ST_WLO) && !is_delim && u_ok;
    assign ev_word_bad = in_valid && (state_q == ST_WLO) && !is_delim && !u_ok;

    // next-state logic
    always_comb begin
        state_d = state_q;
        hidx_d  = hidx_q;
        if (in_valid) begin
            unique case (state_q)
                ST_HUNT: begin
                    if (in_byte == hdr_byte('0)) begin
                        state_d = ST_HDR;
                        hidx_d  = IDX_W'(1);
                    end
                end
                ST_HDR: begin
                    if (in_byte == hdr_byte(hidx_q)) begin
                        if (hidx_q == LAST_IDX) state_d = ST_WHI;
                        else                    hidx_d  = hidx_q + IDX_W'(1);
                    end else if (in_byte == hdr_byte('0)) begin
                        hidx_d  = IDX_W'(1);
                    end else begin
                        state_d = ST_HUNT;
                    end
                end
                ST_WHI:  state_d = is_delim ? ST_HUNT : ST_WLO;
                ST_WLO:  state_d = is_delim ? ST_HUNT : ST_WHI;
                default: state_d = ST_HUNT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            hidx_q  <= '0;
        end else begin
            state_q <= state_d;
            hidx_q  <= hidx_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q        <= '0;
            wr_strobe   <= 1'b0;
            wr_bank     <= '0;
            wr_addr     <= '0;
            wr_data     <= '0;
            dump_req    <= 1'b0;
            status_req  <= 1'b0;
            frame_done  <= 1'b0;
            frame_abort <= 1'b0;
            word_err    <= 1'b0;
        end else begin
            if (in_valid && state_q == ST_WHI) hi_q <= in_byte;
            wr_strobe   <= ev_word_ok;
            dump_req    <= ev_word_ok && bank_sel == BANK_REQ && u_addr == A_DUMP;
            status_req  <= ev_word_ok && bank_sel == BANK_REQ && u_addr == A_STAT;
            frame_done  <= ev_done;
            frame_abort <= ev_abort;
            word_err    <= word_err || ev_word_bad;
            if (ev_word_ok) begin
                wr_bank <= bank_sel;
                wr_addr <= u_addr;
                wr_data <= u_val;
            end
        end
    end

    cmdfr_regbank #(.SLOTS(PT_SLOTS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (ev_word_ok),
        .bank     (bank_sel),
        .addr     (u_addr),
        .data     (u_val),
        .bank_sel (bank_sel),
        .ctl_q    (ctl_q),
        .spi_mode (spi_mode),
        .pt_match (pt_match),
        .pt_mask  (pt_mask)
    );
endmodule

// File: rtl/cmdfr_checker.sv
module cmdfr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       wr_strobe,
    input logic [1:0] wr_bank,
    input logic [3:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       dump_req,
    input logic       status_req,
    input logic       frame_done,
    input logic       frame_abort,
    input logic       word_err,
    input logic [1:0] bank_sel
);
    AST_STROBE_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> $past(in_valid));                                           // R11
    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_strobe, frame_done, frame_abort}));                          // R4
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        word_err |=> word_err);                                                   // R3
    AST_BANK_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && wr_addr == 4'd15) |-> (bank_sel == wr_data[1:0]));          // R6
    AST_DUMP_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
        dump_req |-> (wr_strobe && wr_bank == 2'd0 && wr_addr == 4'd1));          // R8
    AST_STATUS_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
        status_req |-> (wr_strobe && wr_bank == 2'd0 && wr_addr == 4'd2));        // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);                                              // R4
    AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_abort |=> !frame_abort);                                            // R5
endmodule

bind cmdfr_decoder cmdfr_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .wr_strobe   (wr_strobe),
    .wr_bank     (wr_bank),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .dump_req    (dump_req),
    .status_req  (status_req),
    .frame_done  (frame_done),
    .frame_abort (frame_abort),
    .word_err    (word_err),
    .bank_sel    (bank_sel)
);

// File: tb/cmdfr_decoder_tb.sv
`timescale 1ns/1ps
module cmdfr_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        wr_strobe, dump_req, status_req, frame_done, frame_abort, word_err;
    logic [1:0]  wr_bank, bank_sel, spi_mode;
    logic [3:0]  wr_addr;
    logic [7:0]  wr_data, ctl_q;
    logic [31:0] pt_match, pt_mask;

    int total = 0;
    int bad = 0;
    int n_wr = 0, n_dump = 0, n_stat = 0, n_done = 0, n_abort = 0;
    logic [3:0] last_a = '0;
    logic [7:0] last_d = '0;
    logic [1:0] last_b = '0;

    always #10 clk = ~clk;

    cmdfr_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .wr_strobe(wr_strobe), .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_data(wr_data),
        .dump_req(dump_req), .status_req(status_req), .frame_done(frame_done),
        .frame_abort(frame_abort), .word_err(word_err), .bank_sel(bank_sel),
        .ctl_q(ctl_q), .spi_mode(spi_mode), .pt_match(pt_match), .pt_mask(pt_mask)
    );

    always @(negedge clk) begin
        if (wr_strobe) begin
            n_wr++; last_a = wr_addr; last_d = wr_data; last_b = wr_bank;
        end
        if (dump_req)    n_dump++;
        if (status_req)  n_stat++;
        if (frame_done)  n_done++;
        if (frame_abort) n_abort++;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] enc(input logic [3:0] a, input logic [7:0] v);
        return {1'b0, ~v[7], v[7:6], a, 1'b0, ~v[5], v[5:0]};
    endfunction

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk); in_valid = 1'b1; in_byte = b;
        @(negedge clk); in_valid = 1'b0;
        #1;
    endtask

    task automatic send_hdr();
        send_byte(8'h40); send_byte(8'h4C); send_byte(8'h44);
        send_byte(8'h53); send_byte(8'h7E);
    endtask

    task automatic send_word(input logic [3:0] a, input logic [7:0] v);
        logic [15:0] w;
        w = enc(a, v);
        send_byte(w[15:8]); send_byte(w[7:0]);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int w0, d0, a0;
        logic [7:0] cur;
        do_reset();
        // R10: reset state
        check(pt_mask == 32'hFFFF_FFFF, "R10 mask", pt_mask, 32'hFFFF_FFFF);
        check({pt_match, ctl_q, spi_mode, bank_sel, word_err, wr_strobe} == '0,
              "R10 zero", {pt_match, ctl_q}, 0);

        // R1: words without header, broken header, then restart on 0x40
        w0 = n_wr;
        send_word(4'd5, 8'h11);
        send_byte(8'h40); send_byte(8'h4C); send_byte(8'h44); send_byte(8'h00);
        send_word(4'd5, 8'h22);
        check(n_wr == w0, "R1 no frame", n_wr - w0, 0);
        send_byte(8'h40); send_byte(8'h40); send_byte(8'h4C); send_byte(8'h44);
        send_byte(8'h53); send_byte(8'h7E);
        send_word(4'd5, 8'h33);
        check(n_wr == w0 + 1 && last_d == 8'h33, "R1 restart", last_d, 8'h33);
        send_byte(8'h7E);

        // R2/R6: field sweep in bank 1
        send_hdr();
        send_word(4'd15, 8'hFD);
        check(bank_sel == 2'd1 && last_b == 2'd0, "R6 bank", bank_sel, 1);
        d0 = n_dump; a0 = n_stat;
        for (int a = 0; a < 14; a++) begin
            for (int v = 0; v < 256; v++) begin
                send_word(4'(a), 8'(v));
                check(last_a == 4'(a) && last_d == 8'(v) && last_b == 2'd1,
                      "R2 fields", {last_b, last_a, last_d}, {2'd1, 4'(a), 8'(v)});
            end
        end
        check(n_dump == d0 && n_stat == a0, "R8 no req bank1", n_dump - d0, 0);

        // R9: control in bank 1 and bank 2
        send_word(4'd14, 8'hCB);
        check(ctl_q == 8'hCB, "R9 ctl bank1", ctl_q, 8'hCB);
        send_word(4'd15, 8'h02);
        send_word(4'd14, 8'h5A);
        check(ctl_q == 8'h5A, "R9 ctl bank2", ctl_q, 8'h5A);

        // R7: trigger bytes and masks
        for (int v = 0; v < 256; v++) begin
            send_word(4'(v % 4), 8'(v));
            send_word(4'(4 + v % 4), ~8'(v));
            check(pt_match[(v%4)*8 +: 8] == 8'(v), "R7 match", pt_match[(v%4)*8 +: 8], v);
            check(pt_mask[(v%4)*8 +: 8] == ~8'(v), "R7 mask", pt_mask[(v%4)*8 +: 8], ~8'(v));
        end
        for (int m = 0; m < 4; m++) begin
            send_word(4'd8, 8'(m) | 8'hFC);
            check(spi_mode == 2'(m), "R7 spi mode", spi_mode, m);
        end
        d0 = n_dump;
        send_word(4'd1, 8'h01);
        check(n_dump == d0, "R8 no dump bank2", n_dump - d0, 0);

        // R3: corruption sweep on slot 3
        check(word_err == 1'b0, "R3 err clear", word_err, 0);
        cur = pt_match[31:24];
        for (int v = 0; v < 256; v++) begin
            for (int k = 0; k < 5; k++) begin
                logic [15:0] w;
                w = enc(4'd3, 8'(v));
                if (k == 1) w[6]  = ~w[6];
                if (k == 2) w[14] = ~w[14];
                if (k == 3) w[7]  = 1'b1;
                if (k == 4) w[15] = 1'b1;
                if (w[15:8] != 8'h7E && w[7:0] != 8'h7E) begin
                    w0 = n_wr;
                    send_byte(w[15:8]); send_byte(w[7:0]);
                    if (k == 0) cur = 8'(v);
                    check(n_wr - w0 == (k == 0 ? 1 : 0) && pt_match[31:24] == cur,
                          "R3 reject", pt_match[31:24], cur);
                end
            end
        end
        check(word_err == 1'b1, "R3 err sticky", word_err, 1);

        // R4: footer then orphan word
        d0 = n_done; w0 = n_wr;
        send_byte(8'h7E);
        send_word(4'd0, 8'h99);
        check(n_done == d0 + 1 && n_wr == w0, "R4 footer", n_done - d0, 1);

        // R5: abort mid-word, half word discarded
        do_reset();
        a0 = n_abort; w0 = n_wr;
        send_hdr();
        send_byte(enc(4'd1, 8'hC4) >> 8);
        send_byte(8'h7E);
        send_word(4'd1, 8'h77);
        check(n_abort == a0 + 1 && n_wr == w0, "R5 abort", n_abort - a0, 1);
        send_hdr();
        d0 = n_dump; a0 = n_stat;
        send_word(4'd1, 8'h3C);
        check(n_wr == w0 + 1 && last_a == 4'd1 && last_d == 8'h3C, "R5 resync", last_d, 8'h3C);
        // R8: bank 0 requests
        send_word(4'd2, 8'h00);
        check(n_dump == d0 + 1 && n_stat == a0 + 1, "R8 req bank0",
              {n_dump - d0, n_stat - a0}, {32'd1, 32'd1});

        // R11: 0x7E with in_valid low inside a word
        w0 = n_wr; a0 = n_abort;
        send_byte(enc(4'd14, 8'h81) >> 8);
        @(negedge clk); in_byte = 8'h7E;
        repeat (3) @(negedge clk);
        #1;
        send_byte(8'(enc(4'd14, 8'h81)));
        check(n_wr == w0 + 1 && n_abort == a0 && ctl_q == 8'h81, "R11 idle byte", ctl_q, 8'h81);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule